// File: doc/BRIEF.md
# Sprite Memory Page Copy Engine

This block moves one full page of bytes from the processor's address space into the write port of the sprite attribute memory. Software starts it with a single write that gives the page number. The source base address is then that page number in the upper address bits, with the lower offset bits cleared. From that point the block holds the processor stalled through its busy output. It first spends one alignment cycle doing nothing. It then handles each byte in two phases: a bus read of the current source address, followed by a write of the captured byte to the sprite data port.

Every step is timed by a processor-rate clock enable. A parity input marks odd processor cycles, and a read phase may only take place on an odd cycle. Because of this, the first read may slip by one cycle, so a whole transfer stalls the processor for 513 or 514 cycles. The page size, address width and data width are parameters. A generate option can remove the parity alignment.

Top module: `sprite_dma`

## Requirements
- R1: After reset, busy, rd_req and spr_we are all 0.
- R2: A trigger write is accepted only while the engine is passive and in a cycle with cpu_ce = 1. All reads of that transfer then use trig_page as rd_addr[15:8], with rd_addr[7:0] starting at 0x00.
- R3: The first processor cycle in which busy is 1 is an idle cycle: neither rd_req nor spr_we is asserted in it.
- R4: rd_req is asserted only in cycles with cpu_ce = 1 and cyc_odd = 1. A read phase that meets cyc_odd = 0 waits for the next processor cycle.
- R5: Every read is followed, in the next processor cycle, by exactly one spr_we pulse whose spr_wdata equals the rd_data returned for that read. No second read happens before that write.
- R6: The offset rd_addr[7:0] takes the values 0x00 to 0xFF in ascending order, one read per value. Exactly 256 writes happen per transfer.
- R7: busy is 1 from the processor cycle after the accepted trigger up to and including the cycle of the final write. The stall is 513 processor cycles if the trigger arrives with cyc_odd = 1, and 514 if it arrives with cyc_odd = 0.
- R8: A trigger write while busy is 1 has no effect: the page, the offset sequence and the stall length of the running transfer are unchanged.
- R9: In clock cycles with cpu_ce = 0, rd_req and spr_we are 0 and no state advances, so busy is held.
- R10: rd_req and spr_we are never asserted together, and neither is asserted while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | Processor-cycle enable; the engine steps only when it is 1 |
| cyc_odd | input | 1 | 1 during odd processor cycles |
| trig_we | input | 1 | Trigger register write strobe |
| trig_page | input | 8 | Source page number written with the trigger |
| rd_req | output | 1 | Source read request for this cycle |
| rd_addr | output | 16 | Source read address |
| rd_data | input | 8 | Read data, valid in the cycle of rd_req |
| spr_we | output | 1 | Write strobe to the sprite data port |
| spr_wdata | output | 8 | Byte written to the sprite data port |
| busy | output | 1 | Processor halt request while a copy is pending |

## Verification
Several rules are checked by the bound checker on every clock. These include the odd-parity rule for reads and the exclusion of read and write strobes. They also cover silence while cpu_ce is low, the idle first busy cycle, and the pairing of each write with the byte captured by the preceding read. The checker also follows the page and offset sequence of the reads and counts 256 writes when busy falls. Two properties depend on where the trigger lands: the exact 513 versus 514 stall, and the harmlessness of a second trigger during a copy. Only the bench scenarios can show these. They use both start parities, both an always-on enable and a one-in-three enable, and a trigger in the middle of a transfer.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_WAIT1 = 2'd1,
      ST_FETCH = 2'd2,
      ST_STORE = 2'd3
   } sdma_st_e;
endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
   import sdma_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit ALIGN_RD = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ce,
   input  logic     odd,
   input  logic     trig,
   output sdma_st_e st_o,
   output logic     start_o,
   output logic     rd_go_o,
   output logic     wr_go_o,
   output logic     step_o
);
   sdma_st_e         st_q, st_d;
   logic [CNT_W-1:0] left_q, left_d;
   logic             rd_ok;

   generate
      if (ALIGN_RD) begin : g_align
         assign rd_ok = odd;
      end else begin : g_free
         assign rd_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      left_d = left_q;
      case (st_q)
         ST_OFF:   if (trig) st_d = ST_WAIT1;
         ST_WAIT1: begin
            st_d   = ST_FETCH;
            left_d = '1;
         end
         ST_FETCH: if (rd_ok) st_d = ST_STORE;
         ST_STORE: begin
            if (left_q == '0) begin
               st_d = ST_OFF;
            end else begin
               st_d   = ST_FETCH;
               left_d = left_q - 1'b1;
            end
         end
         default:  st_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         left_q <= '0;
      end else if (ce) begin
         st_q   <= st_d;
         left_q <= left_d;
      end
   end

   assign st_o    = st_q;
   assign start_o = ce && trig && (st_q == ST_OFF);
   assign rd_go_o = ce && (st_q == ST_FETCH) && rd_ok;
   assign wr_go_o = ce && (st_q == ST_STORE);
   assign step_o  = wr_go_o && (left_q != '0);
endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 8,
   localparam int PAGE_W = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] page,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (load) begin
         page_q <= page;
         ofs_q  <= '0;
      end else if (step) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign addr = {page_q, ofs_q};
endmodule

// File: rtl/sdma_hold.sv
module sdma_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n)   dout <= '0;
      else if (cap) dout <= din;
   end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
   import sdma_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int OFS_W    = 8,
   parameter int DATA_W   = 8,
   parameter bit ALIGN_RD = 1'b1,
   localparam int PAGE_W  = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ce,
   input  logic              cyc_odd,
   input  logic              trig_we,
   input  logic [PAGE_W-1:0] trig_page,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              spr_we,
   output logic [DATA_W-1:0] spr_wdata,
   output logic              busy
);
   generate
      if (OFS_W < 1 || OFS_W >= ADDR_W) begin : g_bad_ofs
         $error("sprite_dma: OFS_W must lie in 1..ADDR_W-1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sprite_dma: DATA_W must be positive");
      end
   endgenerate

   sdma_st_e st;
   logic     start, rd_go, wr_go, step;

   sdma_seq #(.CNT_W(OFS_W), .ALIGN_RD(ALIGN_RD)) u_seq (
      .clk(clk), .rst_n(rst_n), .ce(cpu_ce), .odd(cyc_odd), .trig(trig_we),
      .st_o(st), .start_o(start), .rd_go_o(rd_go), .wr_go_o(wr_go), .step_o(step)
   );

   sdma_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(start), .page(trig_page),
      .step(step), .addr(rd_addr)
   );

   sdma_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .cap(rd_go), .din(rd_data), .dout(spr_wdata)
   );

   assign rd_req = rd_go;
   assign spr_we = wr_go;
   assign busy   = (st != ST_OFF);
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
   parameter int ADDR_W   = 16,
   parameter int OFS_W    = 8,
   parameter int DATA_W   = 8,
   parameter bit ALIGN_RD = 1'b1,
   localparam int PAGE_W  = ADDR_W - OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ce,
   input logic              cyc_odd,
   input logic              trig_we,
   input logic [PAGE_W-1:0] trig_page,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              spr_we,
   input logic [DATA_W-1:0] spr_wdata,
   input logic              busy
);
   logic [PAGE_W-1:0] page_cap;
   logic [OFS_W:0]    rd_cnt, wr_cnt;
   logic              pend_rd;
   logic [DATA_W-1:0] data_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_cap <= '0;
         rd_cnt   <= '0;
         wr_cnt   <= '0;
         pend_rd  <= 1'b0;
         data_cap <= '0;
      end else begin
         if (trig_we && cpu_ce && !busy) page_cap <= trig_page;
         if (!busy) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
         end else begin
            if (rd_req) rd_cnt <= rd_cnt + 1'b1;
            if (spr_we) wr_cnt <= wr_cnt + 1'b1;
         end
         if (rd_req) begin
            pend_rd  <= 1'b1;
            data_cap <= rd_data;
         end else if (spr_we) begin
            pend_rd  <= 1'b0;
         end
      end
   end

   // R4
   rd_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (cpu_ce && (cyc_odd || !ALIGN_RD)));

   // R10
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && spr_we));

   // R10
   strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || spr_we) |-> busy);

   // R3
   idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!rd_req && !spr_we));

   // R5
   wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spr_we |-> (pend_rd && spr_wdata == data_cap));

   // R5
   no_double_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !pend_rd);

   // R2
   page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[ADDR_W-1:OFS_W] == page_cap));

   // R6
   ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[OFS_W-1:0] == rd_cnt[OFS_W-1:0]));

   // R6
   total_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (wr_cnt == (OFS_W+1)'(1 << OFS_W)));

   // R7
   end_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(spr_we));

   // R9
   ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ce |-> (!rd_req && !spr_we));

   // R9
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ce |=> $stable(busy));
endmodule

bind sprite_dma sprite_dma_chk #(
   .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .ALIGN_RD(ALIGN_RD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .cyc_odd(cyc_odd),
   .trig_we(trig_we), .trig_page(trig_page), .rd_req(rd_req),
   .rd_addr(rd_addr), .rd_data(rd_data), .spr_we(spr_we),
   .spr_wdata(spr_wdata), .busy(busy)
);

// File: tb/sim_sprite_dma.sv
`timescale 1ns/1ps
module sim_sprite_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_ce = 1'b0;
   logic        cyc_odd = 1'b0;
   logic        trig_we = 1'b0;
   logic [7:0]  trig_page = 8'h00;
   logic        rd_req, spr_we, busy;
   logic [15:0] rd_addr;
   logic [7:0]  rd_data, spr_wdata;

   int checks = 0;
   int errors = 0;
   int ce_period = 1;
   int ce_phase = 0;
   int stall_cnt = 0;
   int wr_seen = 0;
   bit seen_busy = 1'b0;
   bit run_mon = 1'b0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];

   always #2 clk = ~clk;

   function automatic logic [7:0] memf(input logic [15:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
   endfunction

   assign rd_data = memf(rd_addr);

   sprite_dma u0 (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .cyc_odd(cyc_odd),
      .trig_we(trig_we), .trig_page(trig_page), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_data(rd_data), .spr_we(spr_we),
      .spr_wdata(spr_wdata), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // processor-rate enable and cycle parity, updated just after each edge
   initial forever begin
      @(posedge clk);
      #1;
      if (cpu_ce) cyc_odd = ~cyc_odd;
      ce_phase = (ce_phase + 1) % ce_period;
      cpu_ce = (ce_phase == 0);
   end

   // monitor: pops the scoreboard as the design produces reads and writes
   initial forever begin
      @(negedge clk);
      if (run_mon) begin
         if (busy && cpu_ce) begin
            stall_cnt++;
            if (!seen_busy) begin
               seen_busy = 1'b1;
               chk(!rd_req && !spr_we, "R3 idle first cycle", {rd_req, spr_we}, 0);
            end
         end
         if (!cpu_ce && (rd_req || spr_we))
            chk(1'b0, "R9 strobe without enable", {rd_req, spr_we}, 0);
         if (rd_req && spr_we)
            chk(1'b0, "R10 both strobes", 3, 0);
         if (rd_req) begin
            chk(cyc_odd == 1'b1, "R4 read parity", cyc_odd, 1);
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read", rd_addr, 0);
            else chk(rd_addr == exp_q[0], "R2 R6 R8 read address", rd_addr, exp_q[0]);
         end
         if (spr_we) begin
            wr_seen++;
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected write", spr_wdata, 0);
            else begin
               chk(spr_wdata == memf(exp_q[0]), "R5 write data", spr_wdata, memf(exp_q[0]));
               void'(exp_q.pop_front());
            end
         end
      end
   end

   // driver: issues a trigger with the wanted parity and loads the scoreboard
   task automatic run_xfer(input logic [7:0] page, input bit want_odd,
                           input bit late_trig, input logic [7:0] late_page);
      do @(negedge clk); while (!(cpu_ce && cyc_odd == want_odd));
      stall_cnt = 0;
      wr_seen   = 0;
      seen_busy = 1'b0;
      for (int i = 0; i < 256; i++) exp_q.push_back({page, 8'(i)});
      trig_we   = 1'b1;
      trig_page = page;
      @(negedge clk);
      trig_we   = 1'b0;
      if (late_trig) begin
         while (wr_seen < 100) @(negedge clk);
         while (!cpu_ce) @(negedge clk);
         trig_we   = 1'b1;
         trig_page = late_page;
         @(negedge clk);
         trig_we   = 1'b0;
      end
      while (!(seen_busy && !busy)) @(negedge clk);
      chk(stall_cnt == (want_odd ? 513 : 514), "R7 stall length", stall_cnt,
          want_odd ? 513 : 514);
      chk(exp_q.size() == 0, "R6 all 256 bytes moved", exp_q.size(), 0);
      chk(wr_seen == 256, "R6 write count", wr_seen, 256);
      repeat (6) @(negedge clk);
      chk(!busy && !rd_req && !spr_we, "R8 no restart after copy",
          {busy, rd_req, spr_we}, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!busy && !rd_req && !spr_we, "R1 reset outputs", {busy, rd_req, spr_we}, 0);
      rst_n = 1'b1;
      run_mon = 1'b1;
      @(negedge clk);
      chk(!busy, "R1 idle after reset", busy, 0);
      run_xfer(8'h02, 1'b1, 1'b0, 8'h00);
      run_xfer(8'hC7, 1'b0, 1'b0, 8'h00);
      ce_period = 3;
      run_xfer(8'h00, 1'b0, 1'b0, 8'h00);
      run_xfer(8'hFF, 1'b1, 1'b1, 8'h40);
      ce_period = 1;
      run_xfer(8'h5A, 1'b0, 1'b1, 8'h11);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule